// File: doc/BRIEF.md
# Unaligned Access Splitter and Merger

This block sits between a load/store unit and a memory port that works on aligned 32-bit longwords. It accepts a byte, word or longword access at any byte address. It turns each access into one or two aligned longword operations and returns read data right-justified. Naturally aligned accesses go to the port as a single operation of their own size. The memory port returns sub-longword read data right-justified and writes only the bytes of that size.

Misaligned accesses fall into three cases: a longword at offset 1, 2 or 3, a word at offset 1, and a word at offset 3. A misaligned write is a read-modify-write of every longword it touches. The caller supplies the physical address of the first byte. It also supplies the physical address of the next page, which is used when the following longword lies on that page. A small state machine issues the operations one at a time over a request/acknowledge handshake. A one-cycle `done` pulse closes every access.

Top module: `lsu_align_unit`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_req`, `done` and `rdata` are 0.
- R2: An access is aligned when `req_pa` AND (bytes−1) is zero, where size code 0 is a byte, 1 a word, and 2 or 3 a longword (code 3 behaves as 2). An aligned access issues exactly one operation with `mem_addr` = `req_pa` and `mem_size` = the size (3 shown as 2). For writes, `mem_wdata` is the data masked to that size. For reads, `rdata` is `mem_rdata` masked to that size.
- R3: A longword read at byte offset bo ≠ 0 reads the low longword and then the high one. It returns (low >> 8·bo) keeping only the 4−bo upper bytes, ORed with (high << (32−8·bo)).
- R4: A word read at offset 1 issues a single longword read and returns bits 23:8 of it.
- R5: A word read at offset 3 reads both longwords and returns low[31:24] in bits 7:0 and high[7:0] in bits 15:8.
- R6: A longword write at offset bo ≠ 0 keeps the low bo bytes of the low longword and fills the rest with the data shifted up by 8·bo. In the high longword it replaces the low bo bytes with the top bo bytes of the data and keeps the others.
- R7: A word write at offset 1 replaces bits 23:8 of one longword. A word write at offset 3 replaces low[31:24] with data[7:0] and high[7:0] with data[15:8].
- R8: The high longword address is `req_pa_next` with bits 1:0 cleared when `req_pa` bits PAGE_BITS−1:2 are all ones. Otherwise it is the low longword address plus 4, wrapped to PA_W bits.
- R9: Misaligned accesses use only longword operations on longword-aligned addresses. All reads come before any write, and the low longword comes before the high one in each phase.
- R10: While `mem_req` is high and `mem_ack` low, `mem_addr`, `mem_we` and `mem_size` hold steady, and `mem_req` stays high.
- R11: `done` pulses for one cycle, in the cycle after the acknowledge of the last operation. `rdata` is valid then and holds until the next read completes; writes leave it unchanged.
- R12: `req_ready` is high only while no operation is in flight. A `req_valid` seen while busy is ignored, and a new request is accepted in the cycle `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2/3 longword |
| req_pa | input | PA_W | Physical address of the first byte |
| req_pa_next | input | PA_W | Physical address on the following page |
| req_wdata | input | 32 | Write data, right-justified |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read result, right-justified |
| mem_req | output | 1 | Memory operation request |
| mem_we | output | 1 | Memory operation is a write |
| mem_size | output | 2 | Operation size: 0 byte, 1 word, 2 longword |
| mem_addr | output | PA_W | Operation address, aligned to its size |
| mem_wdata | output | 32 | Write data, right-justified for sub-longword sizes |
| mem_ack | input | 1 | Memory accepts the operation this cycle |
| mem_rdata | input | 32 | Read data, valid in the acknowledge cycle |

## Verification
Completion of one access and acceptance of the next can fall in the same cycle. The bench issues each new request at the first falling edge on which it sees `done`, so every access after the first is taken while the previous pulse is still high. It then checks that the new access's operation sequence, its result and the memory contents are all unaffected. A request raised for one cycle while the block is busy must leave no trace in the logged operation list. The memory acknowledge is throttled pseudo-randomly so that `done` and the operations land at varying distances from the request.

// File: rtl/ua_pkg.sv
package ua_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ALN, ST_RD_LO, ST_RD_HI, ST_WR_LO, ST_WR_HI
  } ua_state_e;

  // bytes of the low longword kept by a longword insert at offset bo
  function automatic logic [31:0] f_keep_mask(input logic [1:0] bo);
    case (bo)
      2'd0: f_keep_mask = 32'h0000_0000;
      2'd1: f_keep_mask = 32'h0000_00FF;
      2'd2: f_keep_mask = 32'h0000_FFFF;
      default: f_keep_mask = 32'h00FF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] f_size_mask(input logic [1:0] sz);
    if (sz[1]) f_size_mask = 32'hFFFF_FFFF;
    else if (sz[0]) f_size_mask = 32'h0000_FFFF;
    else f_size_mask = 32'h0000_00FF;
  endfunction

  function automatic logic f_aligned(input logic [1:0] sz, input logic [1:0] bo);
    if (sz[1]) f_aligned = (bo == 2'd0);
    else if (sz[0]) f_aligned = !bo[0];
    else f_aligned = 1'b1;
  endfunction

  function automatic logic f_two(input logic [1:0] sz, input logic [1:0] bo);
    f_two = !f_aligned(sz, bo) && (sz[1] || bo == 2'd3);
  endfunction

  function automatic logic [5:0] f_shift(input logic [1:0] bo);
    f_shift = {1'b0, bo, 3'b000};
  endfunction

  function automatic logic [31:0] f_read_merge(input logic [1:0] sz, input logic [1:0] bo,
                                               input logic [31:0] lo, input logic [31:0] hi);
    if (sz[1])
      f_read_merge = ((lo >> f_shift(bo)) & (32'hFFFF_FFFF >> f_shift(bo)))
                   | (hi << (6'd32 - f_shift(bo)));
    else if (bo == 2'd1)
      f_read_merge = {16'h0000, lo[23:8]};
    else
      f_read_merge = {16'h0000, hi[7:0], lo[31:24]};
  endfunction

  function automatic logic [31:0] f_write_lo(input logic [1:0] sz, input logic [1:0] bo,
                                             input logic [31:0] lo, input logic [31:0] d);
    if (sz[1])
      f_write_lo = (lo & f_keep_mask(bo)) | (d << f_shift(bo));
    else if (bo == 2'd1)
      f_write_lo = {lo[31:24], d[15:0], lo[7:0]};
    else
      f_write_lo = {d[7:0], lo[23:0]};
  endfunction

  function automatic logic [31:0] f_write_hi(input logic [1:0] sz, input logic [1:0] bo,
                                             input logic [31:0] hi, input logic [31:0] d);
    if (sz[1])
      f_write_hi = (hi & ~f_keep_mask(bo)) | ((d >> (6'd32 - f_shift(bo))) & f_keep_mask(bo));
    else
      f_write_hi = {hi[31:8], d[15:8]};
  endfunction

endpackage

// File: rtl/ua_addr_gen.sv
module ua_addr_gen #(
  parameter int PA_W      = 30,
  parameter int PAGE_BITS = 9
) (
  input  logic [PA_W-1:0] pa,
  input  logic [PA_W-1:0] pa_next,
  output logic [PA_W-1:0] lo_addr,
  output logic [PA_W-1:0] hi_addr,
  output logic            page_last
);
  localparam int LW_W = PA_W - 2;

  logic [LW_W-1:0] lw_inc;

  assign lw_inc    = pa[PA_W-1:2] + {{(LW_W-1){1'b0}}, 1'b1};
  assign page_last = &pa[PAGE_BITS-1:2];
  assign lo_addr   = {pa[PA_W-1:2], 2'b00};
  assign hi_addr   = page_last ? {pa_next[PA_W-1:2], 2'b00} : {lw_inc, 2'b00};
endmodule

// File: rtl/ua_ctrl.sv
module ua_ctrl import ua_pkg::*; (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      start_aligned,
  input  logic      write,
  input  logic      two,
  input  logic      mem_ack,
  output ua_state_e state,
  output logic      op_fire,
  output logic      op_last
);
  ua_state_e nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  always_comb begin
    op_fire = (state != ST_IDLE) && mem_ack;
    case (state)
      ST_ALN:   op_last = 1'b1;
      ST_RD_LO: op_last = !two && !write;
      ST_RD_HI: op_last = !write;
      ST_WR_LO: op_last = !two;
      ST_WR_HI: op_last = 1'b1;
      default:  op_last = 1'b0;
    endcase
  end

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  if (start)   nxt = start_aligned ? ST_ALN : ST_RD_LO;
      ST_ALN:   if (mem_ack) nxt = ST_IDLE;
      ST_RD_LO: if (mem_ack) nxt = two ? ST_RD_HI : (write ? ST_WR_LO : ST_IDLE);
      ST_RD_HI: if (mem_ack) nxt = write ? ST_WR_LO : ST_IDLE;
      ST_WR_LO: if (mem_ack) nxt = two ? ST_WR_HI : ST_IDLE;
      ST_WR_HI: if (mem_ack) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/ua_merge.sv
module ua_merge import ua_pkg::*; (
  input  logic [1:0]  sz,
  input  logic [1:0]  bo,
  input  logic [31:0] lo,
  input  logic [31:0] hi,
  input  logic [31:0] wdata,
  output logic [31:0] rd_val,
  output logic [31:0] wr_lo,
  output logic [31:0] wr_hi
);
  assign rd_val = f_read_merge(sz, bo, lo, hi);
  assign wr_lo  = f_write_lo(sz, bo, lo, wdata);
  assign wr_hi  = f_write_hi(sz, bo, hi, wdata);
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit import ua_pkg::*; #(
  parameter int PA_W      = 30,
  parameter int PAGE_BITS = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [1:0]      req_size,
  input  logic [PA_W-1:0] req_pa,
  input  logic [PA_W-1:0] req_pa_next,
  input  logic [31:0]     req_wdata,
  output logic            done,
  output logic [31:0]     rdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [1:0]      mem_size,
  output logic [PA_W-1:0] mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic            mem_ack,
  input  logic [31:0]     mem_rdata
);
  ua_state_e       state;
  logic            op_fire, op_last, start;
  logic            req_aligned, req_two, page_last;
  logic [PA_W-1:0] lo_a, hi_a;
  logic [PA_W-1:0] pa_q, lo_q, hi_q;
  logic [1:0]      sz_q, bo_q;
  logic            wr_q, two_q;
  logic [31:0]     wdata_q, lo_d, hi_d, lo_now, hi_now;
  logic [31:0]     rd_merged, wr_lo_val, wr_hi_val;
  logic            done_q;
  logic [31:0]     rdata_q;

  assign req_ready   = (state == ST_IDLE);
  assign start       = req_valid && req_ready;
  assign req_aligned = f_aligned(req_size, req_pa[1:0]);
  assign req_two     = f_two(req_size, req_pa[1:0]);

  ua_addr_gen #(.PA_W(PA_W), .PAGE_BITS(PAGE_BITS)) u_addr (
    .pa(req_pa), .pa_next(req_pa_next),
    .lo_addr(lo_a), .hi_addr(hi_a), .page_last(page_last)
  );

  ua_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .start_aligned(req_aligned),
    .write(wr_q), .two(two_q), .mem_ack(mem_ack),
    .state(state), .op_fire(op_fire), .op_last(op_last)
  );

  assign lo_now = (state == ST_RD_LO) ? mem_rdata : lo_d;
  assign hi_now = (state == ST_RD_HI) ? mem_rdata : hi_d;

  ua_merge u_merge (
    .sz(sz_q), .bo(bo_q), .lo(lo_now), .hi(hi_now), .wdata(wdata_q),
    .rd_val(rd_merged), .wr_lo(wr_lo_val), .wr_hi(wr_hi_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pa_q <= '0; lo_q <= '0; hi_q <= '0;
      sz_q <= '0; bo_q <= '0; wr_q <= 1'b0; two_q <= 1'b0;
      wdata_q <= '0; lo_d <= '0; hi_d <= '0;
      done_q <= 1'b0; rdata_q <= '0;
    end else begin
      done_q <= op_fire && op_last;
      if (start) begin
        pa_q    <= req_pa;
        lo_q    <= lo_a;
        hi_q    <= hi_a;
        sz_q    <= req_size;
        bo_q    <= req_pa[1:0];
        wr_q    <= req_write;
        two_q   <= req_two;
        wdata_q <= req_wdata;
      end
      if (op_fire && state == ST_RD_LO) lo_d <= mem_rdata;
      if (op_fire && state == ST_RD_HI) hi_d <= mem_rdata;
      if (op_fire && op_last && !wr_q)
        rdata_q <= (state == ST_ALN) ? (mem_rdata & f_size_mask(sz_q)) : rd_merged;
    end
  end

  assign done  = done_q;
  assign rdata = rdata_q;

  always_comb begin
    mem_req   = (state != ST_IDLE);
    mem_we    = 1'b0;
    mem_size  = 2'd2;
    mem_addr  = lo_q;
    mem_wdata = '0;
    case (state)
      ST_ALN: begin
        mem_we    = wr_q;
        mem_size  = sz_q[1] ? 2'd2 : sz_q;
        mem_addr  = pa_q;
        mem_wdata = wdata_q & f_size_mask(sz_q);
      end
      ST_RD_HI: mem_addr = hi_q;
      ST_WR_LO: begin
        mem_we    = 1'b1;
        mem_wdata = wr_lo_val;
      end
      ST_WR_HI: begin
        mem_we    = 1'b1;
        mem_addr  = hi_q;
        mem_wdata = wr_hi_val;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ua_align_checker.sv
module ua_align_checker #(
  parameter int PA_W = 30
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            done,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_ack,
  input logic [1:0]      mem_size,
  input logic [PA_W-1:0] mem_addr,
  input logic            op_fire,
  input logic            op_last
);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_size));

  assert_lw_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_size == 2'd2 |-> mem_addr[1:0] == 2'b00);

  assert_word_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_size == 2'd1 |-> !mem_addr[0]);

  assert_done_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    op_fire && op_last |=> done);

  assert_done_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(op_fire && op_last));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && mem_req));
endmodule

bind lsu_align_unit ua_align_checker #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_size(mem_size),
  .mem_addr(mem_addr), .op_fire(op_fire), .op_last(op_last)
);

// File: tb/lsu_align_unit_bench.sv
module lsu_align_unit_bench;
  localparam int PA_W = 12;
  localparam int PAGE_BITS = 6;
  localparam int NW = 1 << (PA_W - 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_size = '0;
  logic [PA_W-1:0] req_pa = '0, req_pa_next = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, done, mem_req, mem_we, mem_ack;
  logic [31:0] rdata, mem_wdata, mem_rdata;
  logic [1:0] mem_size;
  logic [PA_W-1:0] mem_addr;

  int tests = 0, fails = 0, cyc = 0, log_n = 0;
  logic [31:0] mem [NW];
  logic log_we [1024];
  logic [PA_W-1:0] log_addr [1024];
  logic [1:0] log_sz [1024];
  logic ack_edge = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] last_rd = '0;

  always #5 clk = ~clk;

  lsu_align_unit #(.PA_W(PA_W), .PAGE_BITS(PAGE_BITS)) u_lsu_align_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_pa(req_pa),
    .req_pa_next(req_pa_next), .req_wdata(req_wdata), .done(done), .rdata(rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  assign mem_ack = lfsr[0] | lfsr[2];
  always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

  wire [PA_W-3:0] widx = mem_addr[PA_W-1:2];
  always_comb begin
    case (mem_size)
      2'd0:    mem_rdata = (mem[widx] >> {mem_addr[1:0], 3'b000}) & 32'hFF;
      2'd1:    mem_rdata = (mem[widx] >> {mem_addr[1], 4'b0000}) & 32'hFFFF;
      default: mem_rdata = mem[widx];
    endcase
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) mem[i] <= (i * 32'h9E37_79B1) ^ 32'h5A5A_0000;
      log_n <= 0;
      ack_edge <= 1'b0;
    end else begin
      ack_edge <= mem_req && mem_ack;
      if (mem_req && mem_ack) begin
        log_we[log_n % 1024]   <= mem_we;
        log_addr[log_n % 1024] <= mem_addr;
        log_sz[log_n % 1024]   <= mem_size;
        log_n <= log_n + 1;
        if (mem_we) begin
          case (mem_size)
            2'd0:    mem[widx][{mem_addr[1:0], 3'b000} +: 8]  <= mem_wdata[7:0];
            2'd1:    mem[widx][{mem_addr[1], 4'b0000} +: 16] <= mem_wdata[15:0];
            default: mem[widx] <= mem_wdata;
          endcase
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic run_txn(input bit wr, input logic [1:0] sz, input logic [PA_W-1:0] pa,
                         input logic [PA_W-1:0] nxt, input logic [31:0] d);
    int nb, bo, n_exp, start_n, waitc;
    bit aligned, two, page_last;
    logic [PA_W-3:0] lo_i, hi_i;
    logic [31:0] lo_w, hi_w, lo_e, hi_e, exp_rd;
    logic e_we [4];
    logic [PA_W-1:0] e_addr [4];
    logic [1:0] e_sz [4];
    string rtag;
    nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    bo = int'(pa[1:0]);
    aligned = ((int'(pa) & (nb - 1)) == 0);
    two = !aligned && (bo + nb > 4);
    page_last = &pa[PAGE_BITS-1:2];
    lo_i = pa[PA_W-1:2];
    hi_i = page_last ? nxt[PA_W-1:2] : lo_i + 1'b1;
    lo_w = mem[lo_i]; hi_w = mem[hi_i];
    lo_e = lo_w; hi_e = hi_w; exp_rd = '0;
    for (int k = 0; k < nb; k++) begin
      int p;
      p = bo + k;
      if (p < 4) begin
        exp_rd[8*k +: 8] = lo_w[8*p +: 8];
        lo_e[8*p +: 8] = d[8*k +: 8];
      end else begin
        exp_rd[8*k +: 8] = hi_w[8*(p-4) +: 8];
        hi_e[8*(p-4) +: 8] = d[8*k +: 8];
      end
    end
    n_exp = 0;
    if (aligned) begin
      e_we[0] = wr; e_addr[0] = pa; e_sz[0] = sz[1] ? 2'd2 : sz; n_exp = 1;
    end else begin
      e_we[n_exp] = 1'b0; e_addr[n_exp] = {lo_i, 2'b00}; e_sz[n_exp] = 2'd2; n_exp++;
      if (two) begin e_we[n_exp] = 1'b0; e_addr[n_exp] = {hi_i, 2'b00}; e_sz[n_exp] = 2'd2; n_exp++; end
      if (wr) begin
        e_we[n_exp] = 1'b1; e_addr[n_exp] = {lo_i, 2'b00}; e_sz[n_exp] = 2'd2; n_exp++;
        if (two) begin e_we[n_exp] = 1'b1; e_addr[n_exp] = {hi_i, 2'b00}; e_sz[n_exp] = 2'd2; n_exp++; end
      end
    end
    if (aligned) rtag = wr ? "R2 aligned write" : "R2 aligned read";
    else if (sz[1]) rtag = wr ? "R6 long write" : "R3 long read";
    else if (bo == 1) rtag = wr ? "R7 word write off1" : "R4 word read off1";
    else rtag = wr ? "R7 word write off3" : "R5 word read off3";

    waitc = 0;
    while (!req_ready && waitc < 100) begin @(negedge clk); waitc++; end
    start_n = log_n;
    req_valid = 1'b1; req_write = wr; req_size = sz; req_pa = pa;
    req_pa_next = nxt; req_wdata = d;
    @(negedge clk);
    // R12: one-cycle request while busy must be ignored
    req_pa = ~pa; req_write = ~wr; req_wdata = ~d;
    @(negedge clk);
    req_valid = 1'b0;
    waitc = 0;
    while (!done && waitc < 60) begin @(negedge clk); waitc++; end
    check(done == 1'b1, "R11 done seen", {31'b0, done}, 32'd1);
    check(ack_edge && !mem_req, "R11 done after last ack", {30'b0, ack_edge, mem_req}, 32'd2);
    if (!wr) begin
      check(rdata == exp_rd, rtag, rdata, exp_rd);
      last_rd = exp_rd;
    end else begin
      check(rdata == last_rd, "R11 rdata held on write", rdata, last_rd);
      check(mem[lo_i] == lo_e, {rtag, " low"}, mem[lo_i], lo_e);
      check(mem[hi_i] == hi_e, {rtag, " high"}, mem[hi_i], hi_e);
    end
    check(log_n - start_n == n_exp, "R9 R12 op count", log_n - start_n, n_exp);
    if (log_n - start_n == n_exp) begin
      for (int j = 0; j < n_exp; j++) begin
        check(log_we[(start_n + j) % 1024] == e_we[j] && log_sz[(start_n + j) % 1024] == e_sz[j],
              "R9 op kind/order", {29'b0, log_we[(start_n + j) % 1024], log_sz[(start_n + j) % 1024]},
              {29'b0, e_we[j], e_sz[j]});
        check(log_addr[(start_n + j) % 1024] == e_addr[j], "R8 op address",
              32'(log_addr[(start_n + j) % 1024]), 32'(e_addr[j]));
      end
    end
  endtask

  initial begin
    logic [PA_W-1:0] bases [4];
    logic [PA_W-1:0] nexts [4];
    bases[0] = 12'h100; nexts[0] = 12'h500;
    bases[1] = 12'h13C; nexts[1] = 12'h280;
    bases[2] = 12'hFFC; nexts[2] = 12'h010;
    bases[3] = 12'h2A4; nexts[3] = 12'h700;
    repeat (4) @(negedge clk);
    check(req_ready == 1'b1 && mem_req == 1'b0 && done == 1'b0 && rdata == 32'h0,
          "R1 reset state", {rdata[28:0], req_ready, mem_req, done}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    for (int b = 0; b < 4; b++)
      for (int s = 0; s < 4; s++)
        for (int o = 0; o < 4; o++)
          for (int w = 0; w < 2; w++)
            run_txn(w[0], s[1:0], bases[b] | PA_W'(o), nexts[b],
                    32'hC3A5_1E70 ^ (32'(b) << 24) ^ (32'(s) << 16) ^ (32'(o) << 8) ^ 32'(w));
    // read back after writes
    for (int o = 0; o < 4; o++) run_txn(1'b0, 2'd2, 12'h13C | PA_W'(o), 12'h280, 32'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule